// File: doc/BRIEF.md
# Interrupt Gate Dispatch Sequencer

This block carries out the hardware part of entering an interrupt or exception handler. A start pulse supplies a vector number together with the processor state at that moment: current privilege level, interrupt-enable flag, flags word, code selector, instruction pointer, stack selector and stack pointer. The block reads the 64-bit gate descriptor for that vector from an external gate table through a read port with one cycle of latency. It decodes the descriptor and rejects any gate that is not present or whose type is neither interrupt nor trap. It then reads the privilege level of the target code segment through a second read port, also with one cycle of latency.

The privilege rules decide whether entry is allowed. Entry into a level numerically below the current one loads a new stack from a per-level table. The return frame is written one word per clock to a stack-write port.

When the sequence completes, a one-cycle `done` pulse presents the following results: the new code selector, the new instruction pointer, the new privilege level, the new interrupt-enable value, the new stack selector and pointer, and a fault flag. A faulting entry writes nothing to the stack and leaves every reported state value at its value on entry.

Top module: `intr_gate_seq`

## Requirements
- R1: The cycle after a start is accepted while idle, the gate table is read at index `vector`. The descriptor is valid on `gate_rd_data` the following cycle. The segment table is then read at selector bits 15:3, where the selector is descriptor bits 31:16.
- R2: A gate is usable only if descriptor bit 47 is 1 and bits 43:40 equal 1110 (interrupt gate) or 1111 (trap gate). Any other gate ends the sequence with `fault`=1 and no stack write.
- R3: If the target segment level (`seg_rd_dpl`) is numerically greater than the current level, the sequence faults with no stack write.
- R4: When `soft_int`=1, a gate level (descriptor bits 46:45) numerically below the current level faults with no stack write. When `soft_int`=0, the gate level is not checked.
- R5: On a fault, `done` pulses with `new_cpl`, `new_if`, `new_cs`, `new_ip`, `new_ss` and `new_sp` equal to the values captured at start.
- R6: When the target level is below the current level, the stack selector and pointer are taken from entry `target level` of `lvl_ss`/`lvl_sp`. Entry i occupies bits [16i+15:16i] and [32i+31:32i] respectively. The old selector (zero-extended) and then the old pointer are the first two words pushed. Otherwise the current stack is kept.
- R7: After any stack-switch words, the pushes are the flags, then the code selector (zero-extended), then the instruction pointer, and finally `err_code` when `has_err`=1.
- R8: Each push decrements the pointer by 4 and writes at the decremented address. Pushes occur on consecutive cycles, one word per cycle, under the selector on `push_ss`.
- R9: On success, `new_cs` is the descriptor selector and `new_ip` is {bits 63:48, bits 15:0}. `new_cpl` is the target level, `new_ss` is the stack in use, and `new_sp` is the pointer after the last push.
- R10: An interrupt gate returns `new_if`=0. A trap gate returns the captured `cur_if`.
- R11: `done` is a one-cycle pulse in the cycle after the last push, or after the fault decision. A start raised while the block is busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a dispatch (accepted when idle) |
| vector | input | 8 | Vector number |
| soft_int | input | 1 | Entry was requested by software |
| has_err | input | 1 | An error code word is pushed |
| err_code | input | 32 | Error code word |
| cur_cpl | input | 2 | Current privilege level |
| cur_if | input | 1 | Current interrupt-enable flag |
| cur_flags | input | 32 | Flags word to save |
| cur_cs | input | 16 | Code selector to save |
| cur_ip | input | 32 | Instruction pointer to save |
| cur_ss | input | 16 | Current stack selector |
| cur_sp | input | 32 | Current stack pointer |
| lvl_ss | input | 48 | Stack selectors for levels 0..2 |
| lvl_sp | input | 96 | Stack pointers for levels 0..2 |
| gate_rd_en | output | 1 | Gate table read strobe |
| gate_rd_idx | output | 8 | Gate table index |
| gate_rd_data | input | 64 | Gate descriptor, one cycle after the strobe |
| seg_rd_en | output | 1 | Segment table read strobe |
| seg_rd_idx | output | 13 | Segment table index |
| seg_rd_dpl | input | 2 | Segment privilege level, one cycle after the strobe |
| push_valid | output | 1 | Stack write this cycle |
| push_ss | output | 16 | Stack selector of the write |
| push_addr | output | 32 | Address of the write |
| push_data | output | 32 | Word written |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |
| fault | output | 1 | Last dispatch faulted |
| new_cs | output | 16 | Resulting code selector |
| new_ip | output | 32 | Resulting instruction pointer |
| new_cpl | output | 2 | Resulting privilege level |
| new_if | output | 1 | Resulting interrupt-enable flag |
| new_ss | output | 16 | Resulting stack selector |
| new_sp | output | 32 | Resulting stack pointer |

## Verification
The bench targets entries from level 3 through a level-3 gate into level 0. A design that skips the switch, or that reads the wrong table entry, would write the frame onto the user stack. A design that drops the old selector/pointer pair would return a frame two words short. Software entries through a level-0 gate from level 3 must fault, while the same gate taken by hardware must pass; swapping the rule would invert both outcomes. Targets above the current level, non-present gates, unknown type codes, and error-code frames check for spurious pushes, a missing final word, and an interrupt flag left set by an interrupt gate or cleared by a trap gate. A start pulse raised mid-frame must not disturb the frame or produce a second completion.

// File: rtl/igs_pkg.sv
package igs_pkg;
  localparam int DESC_W  = 64;
  localparam int WORD_W  = 32;
  localparam int SEL_W   = 16;
  localparam int LVL_W   = 2;
  localparam int NUM_STK = (1 << LVL_W) - 1;
  localparam int SLOT_N  = 6;

  localparam logic [3:0] TY_INT  = 4'b1110;
  localparam logic [3:0] TY_TRAP = 4'b1111;

  typedef enum logic [2:0] {
    S_IDLE, S_GATE, S_SEG, S_CHK, S_PUSH, S_FIN
  } seq_st_t;

  typedef struct packed {
    logic              present;
    logic [LVL_W-1:0]  gdpl;
    logic [3:0]        gtype;
    logic [SEL_W-1:0]  sel;
    logic [WORD_W-1:0] ofs;
  } gate_t;

  // number of words in the return frame
  function automatic logic [2:0] frame_len(input logic sw, input logic err);
    logic [2:0] n;
    n = 3'd3;
    if (sw)  n = n + 3'd2;
    if (err) n = n + 3'd1;
    return n;
  endfunction

  // slot order: 0 old ss, 1 old sp, 2 flags, 3 cs, 4 ip, 5 error code
  function automatic logic [2:0] frame_slot(input logic sw, input logic [2:0] k);
    return sw ? k : (k + 3'd2);
  endfunction
endpackage

// File: rtl/igs_gate_decode.sv
module igs_gate_decode
  import igs_pkg::*;
(
  input  logic [DESC_W-1:0] desc_i,
  output gate_t             gate_o,
  output logic              bad_o
);
  always_comb begin
    gate_o.present = desc_i[47];
    gate_o.gdpl    = desc_i[46:45];
    gate_o.gtype   = desc_i[43:40];
    gate_o.sel     = desc_i[31:16];
    gate_o.ofs     = {desc_i[63:48], desc_i[15:0]};
  end

  assign bad_o = !gate_o.present ||
                 !((gate_o.gtype == TY_INT) || (gate_o.gtype == TY_TRAP));

  logic unused_rsvd;
  assign unused_rsvd = ^{desc_i[39:32], desc_i[44]};
endmodule

// File: rtl/igs_priv_check.sv
module igs_priv_check
  import igs_pkg::*;
(
  input  logic [LVL_W-1:0] gate_dpl_i,
  input  logic [LVL_W-1:0] tgt_dpl_i,
  input  logic [LVL_W-1:0] cur_cpl_i,
  input  logic             soft_i,
  output logic             fault_o,
  output logic             switch_o
);
  logic tgt_too_low;
  logic gate_denied;

  assign tgt_too_low = tgt_dpl_i > cur_cpl_i;
  assign gate_denied = soft_i && (gate_dpl_i < cur_cpl_i);
  assign fault_o     = tgt_too_low || gate_denied;
  assign switch_o    = tgt_dpl_i < cur_cpl_i;
endmodule

// File: rtl/igs_frame_mux.sv
module igs_frame_mux
  import igs_pkg::*;
(
  input  logic [SEL_W-1:0]  old_ss_i,
  input  logic [WORD_W-1:0] old_sp_i,
  input  logic [WORD_W-1:0] flags_i,
  input  logic [SEL_W-1:0]  cs_i,
  input  logic [WORD_W-1:0] ip_i,
  input  logic [WORD_W-1:0] err_i,
  input  logic              switch_i,
  input  logic [2:0]        idx_i,
  output logic [WORD_W-1:0] word_o
);
  logic [WORD_W-1:0] slots [SLOT_N];
  logic [2:0]        slot;

  assign slots[0] = WORD_W'(old_ss_i);
  assign slots[1] = old_sp_i;
  assign slots[2] = flags_i;
  assign slots[3] = WORD_W'(cs_i);
  assign slots[4] = ip_i;
  assign slots[5] = err_i;

  assign slot = frame_slot(switch_i, idx_i);

  always_comb begin
    word_o = '0;
    for (int i = 0; i < SLOT_N; i++)
      if (slot == 3'(i)) word_o = slots[i];
  end
endmodule

// File: rtl/intr_gate_seq.sv
module intr_gate_seq
  import igs_pkg::*;
#(
  parameter int VEC_W     = 8,
  parameter int SEG_IDX_W = 13
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      start,
  input  logic [VEC_W-1:0]          vector,
  input  logic                      soft_int,
  input  logic                      has_err,
  input  logic [WORD_W-1:0]         err_code,
  input  logic [LVL_W-1:0]          cur_cpl,
  input  logic                      cur_if,
  input  logic [WORD_W-1:0]         cur_flags,
  input  logic [SEL_W-1:0]          cur_cs,
  input  logic [WORD_W-1:0]         cur_ip,
  input  logic [SEL_W-1:0]          cur_ss,
  input  logic [WORD_W-1:0]         cur_sp,
  input  logic [NUM_STK*SEL_W-1:0]  lvl_ss,
  input  logic [NUM_STK*WORD_W-1:0] lvl_sp,
  output logic                      gate_rd_en,
  output logic [VEC_W-1:0]          gate_rd_idx,
  input  logic [DESC_W-1:0]         gate_rd_data,
  output logic                      seg_rd_en,
  output logic [SEG_IDX_W-1:0]      seg_rd_idx,
  input  logic [LVL_W-1:0]          seg_rd_dpl,
  output logic                      push_valid,
  output logic [SEL_W-1:0]          push_ss,
  output logic [WORD_W-1:0]         push_addr,
  output logic [WORD_W-1:0]         push_data,
  output logic                      busy,
  output logic                      done,
  output logic                      fault,
  output logic [SEL_W-1:0]          new_cs,
  output logic [WORD_W-1:0]         new_ip,
  output logic [LVL_W-1:0]          new_cpl,
  output logic                      new_if,
  output logic [SEL_W-1:0]          new_ss,
  output logic [WORD_W-1:0]         new_sp
);
  localparam int          LVL_N = 1 << LVL_W;
  localparam logic [WORD_W-1:0] WSTEP = WORD_W'(WORD_W / 8);

  seq_st_t st;

  // captured entry state
  logic [VEC_W-1:0]  vec_q;
  logic              soft_q, haserr_q, if_q;
  logic [WORD_W-1:0] err_q, flags_q, ip_q, sp_q;
  logic [LVL_W-1:0]  cpl_q;
  logic [SEL_W-1:0]  cs_q, ss_q;

  // decoded gate fields kept for the privilege step
  logic [LVL_W-1:0]  gdpl_q;
  logic              is_int_q;
  logic [SEL_W-1:0]  gsel_q;
  logic [WORD_W-1:0] gofs_q;

  // frame state
  logic              sw_q;
  logic [2:0]        k_q, len_q;
  logic [SEL_W-1:0]  wss_q;
  logic [WORD_W-1:0] wsp_q;
  logic              fault_q;

  // per-level stack table
  logic [SEL_W-1:0]  stk_ss_a [LVL_N];
  logic [WORD_W-1:0] stk_sp_a [LVL_N];

  for (genvar i = 0; i < LVL_N; i++) begin : g_stk
    if (i < NUM_STK) begin : g_ent
      assign stk_ss_a[i] = lvl_ss[i*SEL_W +: SEL_W];
      assign stk_sp_a[i] = lvl_sp[i*WORD_W +: WORD_W];
    end else begin : g_none
      assign stk_ss_a[i] = '0;
      assign stk_sp_a[i] = '0;
    end
  end

  // named internal events
  gate_t dec_gate;
  logic  dec_bad;
  logic  priv_flt, need_sw;
  logic  bad_gate_evt, priv_fault_evt, accept_evt, last_push_evt;

  igs_gate_decode u_dec (
    .desc_i (gate_rd_data),
    .gate_o (dec_gate),
    .bad_o  (dec_bad)
  );

  igs_priv_check u_priv (
    .gate_dpl_i (gdpl_q),
    .tgt_dpl_i  (seg_rd_dpl),
    .cur_cpl_i  (cpl_q),
    .soft_i     (soft_q),
    .fault_o    (priv_flt),
    .switch_o   (need_sw)
  );

  igs_frame_mux u_mux (
    .old_ss_i (ss_q),
    .old_sp_i (sp_q),
    .flags_i  (flags_q),
    .cs_i     (cs_q),
    .ip_i     (ip_q),
    .err_i    (err_q),
    .switch_i (sw_q),
    .idx_i    (k_q),
    .word_o   (push_data)
  );

  assign accept_evt     = (st == S_IDLE) && start;
  assign bad_gate_evt   = (st == S_SEG) && dec_bad;
  assign priv_fault_evt = (st == S_CHK) && priv_flt;
  assign last_push_evt  = (st == S_PUSH) && (k_q == len_q - 3'd1);

  assign gate_rd_en  = (st == S_GATE);
  assign gate_rd_idx = vec_q;
  assign seg_rd_en   = (st == S_SEG) && !dec_bad;
  assign seg_rd_idx  = dec_gate.sel[SEL_W-1 -: SEG_IDX_W];
  assign push_valid  = (st == S_PUSH);
  assign push_addr   = wsp_q - WSTEP;
  assign push_ss     = wss_q;
  assign busy        = (st != S_IDLE);
  assign done        = (st == S_FIN);
  assign fault       = fault_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      vec_q    <= '0;
      soft_q   <= 1'b0;
      haserr_q <= 1'b0;
      if_q     <= 1'b0;
      err_q    <= '0;
      flags_q  <= '0;
      ip_q     <= '0;
      sp_q     <= '0;
      cpl_q    <= '0;
      cs_q     <= '0;
      ss_q     <= '0;
      gdpl_q   <= '0;
      is_int_q <= 1'b0;
      gsel_q   <= '0;
      gofs_q   <= '0;
      sw_q     <= 1'b0;
      k_q      <= '0;
      len_q    <= '0;
      wss_q    <= '0;
      wsp_q    <= '0;
      fault_q  <= 1'b0;
      new_cs   <= '0;
      new_ip   <= '0;
      new_cpl  <= '0;
      new_if   <= 1'b0;
      new_ss   <= '0;
      new_sp   <= '0;
    end else begin
      case (st)
        S_IDLE: if (start) begin
          vec_q    <= vector;
          soft_q   <= soft_int;
          haserr_q <= has_err;
          if_q     <= cur_if;
          err_q    <= err_code;
          flags_q  <= cur_flags;
          ip_q     <= cur_ip;
          sp_q     <= cur_sp;
          cpl_q    <= cur_cpl;
          cs_q     <= cur_cs;
          ss_q     <= cur_ss;
          fault_q  <= 1'b0;
          // results default to the entry state; success overwrites them
          new_cs   <= cur_cs;
          new_ip   <= cur_ip;
          new_cpl  <= cur_cpl;
          new_if   <= cur_if;
          new_ss   <= cur_ss;
          new_sp   <= cur_sp;
          st       <= S_GATE;
        end
        S_GATE: st <= S_SEG;
        S_SEG: begin
          if (dec_bad) begin
            fault_q <= 1'b1;
            st      <= S_FIN;
          end else begin
            gdpl_q   <= dec_gate.gdpl;
            is_int_q <= (dec_gate.gtype == TY_INT);
            gsel_q   <= dec_gate.sel;
            gofs_q   <= dec_gate.ofs;
            st       <= S_CHK;
          end
        end
        S_CHK: begin
          if (priv_flt) begin
            fault_q <= 1'b1;
            st      <= S_FIN;
          end else begin
            sw_q    <= need_sw;
            wss_q   <= need_sw ? stk_ss_a[seg_rd_dpl] : ss_q;
            wsp_q   <= need_sw ? stk_sp_a[seg_rd_dpl] : sp_q;
            new_ss  <= need_sw ? stk_ss_a[seg_rd_dpl] : ss_q;
            len_q   <= frame_len(need_sw, haserr_q);
            k_q     <= '0;
            new_cs  <= gsel_q;
            new_ip  <= gofs_q;
            new_cpl <= seg_rd_dpl;
            new_if  <= is_int_q ? 1'b0 : if_q;
            st      <= S_PUSH;
          end
        end
        S_PUSH: begin
          wsp_q <= wsp_q - WSTEP;
          k_q   <= k_q + 3'd1;
          if (last_push_evt) begin
            new_sp <= wsp_q - WSTEP;
            st     <= S_FIN;
          end
        end
        S_FIN:   st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  // ---------------- assertions ----------------
  p_gate_read_r1: assert property (@(posedge clk) disable iff (!rst_n)
    accept_evt |=> (gate_rd_en && gate_rd_idx == $past(vector)));

  p_bad_gate_r2: assert property (@(posedge clk) disable iff (!rst_n)
    bad_gate_evt |=> (done && fault && !push_valid));

  p_priv_fault_r3: assert property (@(posedge clk) disable iff (!rst_n)
    priv_fault_evt |=> (done && fault && !push_valid));

  p_fault_keeps_cpl_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (done && fault) |-> (new_cpl == cpl_q && new_if == if_q));

  p_push_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (push_valid && $past(push_valid)) |-> (push_addr == $past(push_addr) - WSTEP));

  p_cpl_no_rise_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !fault) |-> (new_cpl <= cpl_q));

  p_if_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !fault && is_int_q) |-> !new_if);

  p_done_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_push_then_done_r11: assert property (@(posedge clk) disable iff (!rst_n)
    last_push_evt |=> (done && !push_valid));
endmodule

// File: tb/intr_gate_seq_tb.sv
module intr_gate_seq_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic        start = 0, soft_int = 0, has_err = 0, cur_if = 0;
  logic [7:0]  vector = 0;
  logic [31:0] err_code = 0, cur_flags = 0, cur_ip = 0, cur_sp = 0;
  logic [1:0]  cur_cpl = 0;
  logic [15:0] cur_cs = 0, cur_ss = 0;
  logic [47:0] lvl_ss;
  logic [95:0] lvl_sp;
  logic        gate_rd_en, seg_rd_en;
  logic [7:0]  gate_rd_idx;
  logic [63:0] gate_rd_data = 0;
  logic [12:0] seg_rd_idx;
  logic [1:0]  seg_rd_dpl = 0;
  logic        push_valid, busy, done, fault, new_if;
  logic [15:0] push_ss, new_cs, new_ss;
  logic [31:0] push_addr, push_data, new_ip, new_sp;
  logic [1:0]  new_cpl;

  intr_gate_seq dut_i (.*);

  logic [63:0] gmem [256];
  logic [15:0] tss_sel [3];
  logic [31:0] tsp [3];

  int n_chk = 0, n_err = 0;

  assign lvl_ss = {tss_sel[2], tss_sel[1], tss_sel[0]};
  assign lvl_sp = {tsp[2], tsp[1], tsp[0]};

  function automatic logic [1:0] seg_lvl(input logic [12:0] idx);
    return idx[1:0] ^ idx[3:2];
  endfunction

  always @(posedge clk) begin
    if (gate_rd_en) gate_rd_data <= gmem[gate_rd_idx];
    if (seg_rd_en)  seg_rd_dpl   <= seg_lvl(seg_rd_idx);
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [63:0] mk_gate(input logic p, input logic [1:0] gd,
      input logic [3:0] ty, input logic [15:0] sel, input logic [31:0] ofs);
    logic [63:0] g;
    g = 64'(ofs[15:0]);
    g = g | (64'(sel) << 16);
    g = g | (64'(ty) << 40);
    g = g | (64'(gd) << 45);
    g = g | (64'(p) << 47);
    g = g | (64'(ofs[31:16]) << 48);
    return g;
  endfunction

  // one dispatch, compared against an independent model
  task automatic run_one(input logic [7:0] v, input logic sft, input logic he,
                         input logic [1:0] cpl, input logic ifl, input bit poke);
    logic [63:0] g;
    logic [1:0]  gd, td;
    logic [3:0]  ty;
    logic [15:0] sel;
    logic [31:0] ofs, sp0, ew [6];
    logic [15:0] ess;
    bit   bad, pf, sw, got_done;
    int   nexp, nact, cyc;
    logic [31:0] aa [8], ad [8];
    logic [15:0] as [8];

    g   = gmem[v];
    bad = (g[47] == 1'b0) || ((g[43:40] != 4'hE) && (g[43:40] != 4'hF));
    gd  = g[46:45];
    ty  = g[43:40];
    sel = g[31:16];
    ofs = {g[63:48], g[15:0]};
    td  = seg_lvl(sel[15:3]);
    pf  = !bad && ((td > cpl) || (sft && (gd < cpl)));
    sw  = !bad && !pf && (td < cpl);

    @(negedge clk);
    vector = v; soft_int = sft; has_err = he; cur_cpl = cpl; cur_if = ifl;
    err_code = $urandom; cur_flags = $urandom; cur_ip = $urandom;
    cur_cs = 16'($urandom); cur_ss = 16'($urandom);
    cur_sp = {$urandom, 2'b00} + 32'h100;
    start = 1;
    @(negedge clk);
    start = 0;

    nexp = 0;
    ess  = sw ? tss_sel[td] : cur_ss;
    sp0  = sw ? tsp[td] : cur_sp;
    if (sw) begin ew[nexp] = 32'(cur_ss); nexp++; ew[nexp] = cur_sp; nexp++; end
    ew[nexp] = cur_flags; nexp++;
    ew[nexp] = 32'(cur_cs); nexp++;
    ew[nexp] = cur_ip; nexp++;
    if (he) begin ew[nexp] = err_code; nexp++; end
    if (bad || pf) nexp = 0;

    nact = 0; got_done = 0; cyc = 0;
    while (!got_done && cyc < 40) begin
      if (push_valid && nact < 8) begin
        aa[nact] = push_addr; ad[nact] = push_data; as[nact] = push_ss;
        nact++;
        if (poke) begin start = 1; vector = ~v; end
      end else if (poke) start = 0;
      if (done) got_done = 1;
      else begin @(negedge clk); cyc++; end
    end
    start = 0;
    chk(got_done, "R11", "done seen", got_done, 1);
    chk(fault == (bad || pf), bad ? "R2" : (pf ? "R3/R4" : "R3"), "fault", fault, bad || pf);
    chk(nact == nexp, "R7", "push count", nact, nexp);
    for (int i = 0; i < nact && i < nexp; i++) begin
      chk(ad[i] == ew[i], sw && i < 2 ? "R6" : "R7", "push word", ad[i], ew[i]);
      chk(aa[i] == sp0 - 32'(4*(i+1)), "R8", "push addr", aa[i], sp0 - 32'(4*(i+1)));
      chk(as[i] == ess, "R6", "push ss", as[i], ess);
    end
    if (bad || pf) begin
      chk(new_cpl == cpl && new_if == ifl, "R5", "fault cpl/if", {new_cpl, new_if}, {cpl, ifl});
      chk(new_sp == cur_sp && new_ss == cur_ss, "R5", "fault stack", new_sp, cur_sp);
      chk(new_cs == cur_cs && new_ip == cur_ip, "R5", "fault cs/ip", new_ip, cur_ip);
    end else begin
      chk(new_cs == sel, "R9", "new_cs", new_cs, sel);
      chk(new_ip == ofs, "R9", "new_ip", new_ip, ofs);
      chk(new_cpl == td, "R9", "new_cpl", new_cpl, td);
      chk(new_ss == ess, "R9", "new_ss", new_ss, ess);
      chk(new_sp == sp0 - 32'(4*nexp), "R9", "new_sp", new_sp, sp0 - 32'(4*nexp));
      chk(new_if == ((ty == 4'hE) ? 1'b0 : ifl), "R10", "new_if", new_if, (ty == 4'hE) ? 1'b0 : ifl);
    end
    @(negedge clk);
    chk(!done, "R11", "done one cycle", done, 0);
    if (poke) begin
      for (int i = 0; i < 6; i++) begin
        chk(!busy && !push_valid, "R11", "start while busy ignored", busy, 0);
        @(negedge clk);
      end
    end
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog: actual=expired expected=finished");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    tss_sel[0] = 16'h0010; tss_sel[1] = 16'h0021; tss_sel[2] = 16'h0032;
    tsp[0] = 32'h0000_8000; tsp[1] = 32'h0001_0000; tsp[2] = 32'h0002_0000;
    for (int v = 0; v < 256; v++) begin
      int r;
      logic [3:0] ty;
      r  = $urandom % 10;
      ty = (r == 1) ? 4'($urandom % 14) : ((r < 6) ? 4'hE : 4'hF);
      gmem[v] = mk_gate(r != 0, 2'($urandom), ty, 16'($urandom), $urandom);
    end
    // directed gates; selector index low bits choose target level
    gmem[0] = mk_gate(1, 2'd3, 4'hE, 16'h0000, 32'hC000_1234); // target 0, user callable
    gmem[1] = mk_gate(1, 2'd0, 4'hF, 16'h0000, 32'hC000_5678); // target 0, kernel-only
    gmem[2] = mk_gate(1, 2'd3, 4'hE, 16'h0018, 32'h0040_0000); // target 3
    gmem[3] = mk_gate(0, 2'd3, 4'hE, 16'h0000, 32'h1);         // not present
    gmem[4] = mk_gate(1, 2'd3, 4'h6, 16'h0000, 32'h2);         // unknown type
    gmem[5] = mk_gate(1, 2'd3, 4'hF, 16'h0010, 32'h0BAD_0001); // target 2

    repeat (3) @(negedge clk);
    chk(!busy && !done && !push_valid && !gate_rd_en, "R11", "reset idle",
        {busy, done, push_valid}, 0);
    chk(!fault && new_cpl == 0, "R5", "reset outputs", fault, 0);
    rst_n = 1;
    @(negedge clk);

    run_one(8'd0, 1, 1, 2'd3, 1, 0);  // R6: user -> kernel via software, with error code
    run_one(8'd0, 0, 0, 2'd3, 1, 0);  // R10: interrupt gate clears flag
    run_one(8'd1, 0, 0, 2'd3, 1, 0);  // R4: hardware ignores gate level
    run_one(8'd1, 1, 0, 2'd3, 1, 0);  // R4: software denied
    run_one(8'd2, 0, 0, 2'd0, 1, 0);  // R3: target above current
    run_one(8'd2, 1, 1, 2'd3, 0, 0);  // R7: same level, no switch
    run_one(8'd3, 0, 0, 2'd0, 1, 0);  // R2: not present
    run_one(8'd4, 0, 0, 2'd0, 1, 0);  // R2: bad type
    run_one(8'd5, 0, 1, 2'd3, 1, 0);  // R6: switch to level 2, trap keeps flag
    run_one(8'd1, 0, 1, 2'd0, 0, 0);  // R1: kernel to kernel
    run_one(8'd0, 1, 1, 2'd3, 1, 1);  // R11: start pulsed mid-frame
    for (int i = 0; i < 300; i++)
      run_one(8'($urandom), 1'($urandom), 1'($urandom), 2'($urandom), 1'($urandom), 0);

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule